// File: doc/BRIEF.md
# Supervisor System Instruction Checker

This block sits in the execute stage of a core that supports a supervisor privilege level. It watches each instruction word and picks out two privileged system operations: the address-translation fence and the return from a supervisor trap. For either one it looks at the current privilege level, the two trap-control status bits and whether supervisor mode is built in. From these it either flags the instruction as illegal or issues the matching action. A fence produces a translation-cache flush request, and each of its two operands can narrow that request. A legal return produces a redirect to the saved supervisor exception PC, together with the status values to write back.

All outputs are registered. They appear one clock after the instruction is presented with its valid flag, and each lasts a single cycle. Any other instruction word leaves every output at zero. The translation cache itself, trap entry and the register file are outside this block. The caller passes in the operand values that the register specifiers select.

Top module: `sys_instr_check`

## Requirements
- R1: A word is a fence only when bits 14:0 equal 0x0073 and bits 31:25 equal 0x09. The rs1 specifier is bits 19:15 and the rs2 specifier is bits 24:20. Any other word that is not the return word drives illegal, flush and return outputs to 0.
- R2: The supervisor return is recognised only for the exact word 0x10200073. A word differing in any bit produces no output.
- R3: Privilege is encoded as user = 2'b00, supervisor = 2'b01, machine = 2'b11. A fence in user mode raises illegal and issues no flush.
- R4: A fence in supervisor mode raises illegal when the trap-virtual-memory bit is 1. When that bit is 0 it issues a flush without illegal.
- R5: A fence in machine mode always issues a flush, whatever the trap-virtual-memory bit is.
- R6: When the rs1 specifier is 0, the flush covers all addresses (address-valid = 0, address = 0). Otherwise address-valid = 1 and the address equals the rs1 operand value, even when that value is zero.
- R7: When the rs2 specifier is 0, the flush covers all address spaces (space-valid = 0, space = 0). Otherwise space-valid = 1 and the space equals the rs2 operand value.
- R8: A supervisor return in user mode is always illegal.
- R9: A supervisor return in supervisor mode is illegal when supervisor mode is not implemented or the trap-return bit is 1. In machine mode it is illegal only when supervisor mode is not implemented.
- R10: A legal supervisor return pulses the return request with target PC = the saved supervisor exception PC. It also gives next privilege = supervisor if the saved previous-privilege bit is 1 and user otherwise, interrupt enable = the saved previous-enable bit, previous-enable = 1 and previous-privilege = 0.
- R11: Outputs follow the presenting cycle by exactly one clock and last one cycle. With valid low every output is 0. The reserved privilege code 2'b10 makes either instruction illegal.
- R12: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| priv | input | 2 | Current privilege level |
| tvm | input | 1 | Trap fences taken in supervisor mode |
| tsr | input | 1 | Trap returns taken in supervisor mode |
| s_impl | input | 1 | Supervisor mode is implemented |
| rs1_val | input | XLEN | Value of the register named by rs1 |
| rs2_val | input | XLEN | Value of the register named by rs2 |
| sepc | input | XLEN | Saved supervisor exception PC |
| spp | input | 1 | Saved previous-privilege bit |
| spie | input | 1 | Saved previous-enable bit |
| illegal | output | 1 | Illegal-instruction pulse |
| flush_req | output | 1 | Translation flush request pulse |
| flush_addr_vld | output | 1 | Flush is limited to one address |
| flush_addr | output | XLEN | Address qualifier |
| flush_asid_vld | output | 1 | Flush is limited to one address space |
| flush_asid | output | XLEN | Address-space qualifier |
| ret_req | output | 1 | Supervisor return redirect pulse |
| ret_pc | output | XLEN | Redirect target |
| ret_priv | output | 2 | Privilege after return |
| ret_sie | output | 1 | Interrupt enable after return |
| ret_spie | output | 1 | Previous-enable after return |
| ret_spp | output | 1 | Previous-privilege after return |

## Verification
The assertions check on every cycle that the three pulses never overlap and that a flush never follows a user-mode or trapped supervisor-mode request. They also check that a return only follows a cycle in which supervisor mode was implemented and carries the exception PC seen then, and that nothing follows an invalid cycle. Exact decoding is left to the bench's directed scenarios: the mask for the fence, the single return word, each privilege and status combination, the operand qualifiers with specifiers of zero and non-zero, and the saved-bit restore values.

// File: rtl/sys_instr_check.sv
module sys_instr_check #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [31:0]     instr,
  input  logic [1:0]      priv,
  input  logic            tvm,
  input  logic            tsr,
  input  logic            s_impl,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic [XLEN-1:0] sepc,
  input  logic            spp,
  input  logic            spie,
  output logic            illegal,
  output logic            flush_req,
  output logic            flush_addr_vld,
  output logic [XLEN-1:0] flush_addr,
  output logic            flush_asid_vld,
  output logic [XLEN-1:0] flush_asid,
  output logic            ret_req,
  output logic [XLEN-1:0] ret_pc,
  output logic [1:0]      ret_priv,
  output logic            ret_sie,
  output logic            ret_spie,
  output logic            ret_spp
);

  localparam logic [1:0]  PRV_U     = 2'b00;
  localparam logic [1:0]  PRV_S     = 2'b01;
  localparam logic [1:0]  PRV_M     = 2'b11;
  localparam logic [31:0] SRET_WORD = 32'h1020_0073;

  wire       is_fence = (instr[31:25] == 7'h09) && (instr[14:0] == 15'h0073);
  wire       is_sret  = (instr == SRET_WORD);
  wire [4:0] rs1_f    = instr[19:15];
  wire [4:0] rs2_f    = instr[24:20];

  logic fence_ok, sret_ok;

  always_comb begin
    case (priv)
      PRV_S:   fence_ok = !tvm;
      PRV_M:   fence_ok = 1'b1;
      default: fence_ok = 1'b0;
    endcase
    case (priv)
      PRV_S:   sret_ok = s_impl && !tsr;
      PRV_M:   sret_ok = s_impl;
      default: sret_ok = 1'b0;
    endcase
  end

  wire go_fence = instr_valid && is_fence && fence_ok;
  wire go_sret  = instr_valid && is_sret && sret_ok;
  wire go_ill   = instr_valid && ((is_fence && !fence_ok) || (is_sret && !sret_ok));
  wire addr_lim = go_fence && (rs1_f != 5'd0);
  wire asid_lim = go_fence && (rs2_f != 5'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      illegal        <= 1'b0;
      flush_req      <= 1'b0;
      flush_addr_vld <= 1'b0;
      flush_addr     <= '0;
      flush_asid_vld <= 1'b0;
      flush_asid     <= '0;
      ret_req        <= 1'b0;
      ret_pc         <= '0;
      ret_priv       <= PRV_U;
      ret_sie        <= 1'b0;
      ret_spie       <= 1'b0;
      ret_spp        <= 1'b0;
    end else begin
      illegal        <= go_ill;
      flush_req      <= go_fence;
      flush_addr_vld <= addr_lim;
      flush_addr     <= addr_lim ? rs1_val : '0;
      flush_asid_vld <= asid_lim;
      flush_asid     <= asid_lim ? rs2_val : '0;
      ret_req        <= go_sret;
      ret_pc         <= go_sret ? sepc : '0;
      ret_priv       <= (go_sret && spp) ? PRV_S : PRV_U;
      ret_sie        <= go_sret && spie;
      ret_spie       <= go_sret;
      ret_spp        <= 1'b0;
    end
  end

endmodule

// File: rtl/sys_instr_check_chk.sv
module sys_instr_check_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_valid,
  input logic [1:0]      priv,
  input logic            tvm,
  input logic            s_impl,
  input logic [XLEN-1:0] sepc,
  input logic            illegal,
  input logic            flush_req,
  input logic            ret_req,
  input logic [XLEN-1:0] ret_pc
);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({illegal, flush_req, ret_req}) <= 1); // R11

  AST_NO_USER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(priv) != 2'b00); // R3

  AST_TVM_BLOCKS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(instr_valid && priv == 2'b01 && tvm) |-> !flush_req); // R4

  AST_RET_NEEDS_SMODE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |-> $past(s_impl) && $past(priv) != 2'b00); // R9

  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |-> ret_pc == $past(sepc)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(instr_valid) |-> !illegal && !flush_req && !ret_req); // R11

endmodule

bind sys_instr_check sys_instr_check_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .priv(priv),
  .tvm(tvm), .s_impl(s_impl), .sepc(sepc), .illegal(illegal),
  .flush_req(flush_req), .ret_req(ret_req), .ret_pc(ret_pc)
);

// File: tb/sim_sys_instr_check.sv
module sim_sys_instr_check;
  localparam int CLK_P = 10;
  localparam int XLEN  = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            instr_valid = 1'b0;
  logic [31:0]     instr = '0;
  logic [1:0]      priv = 2'b00;
  logic            tvm = 1'b0, tsr = 1'b0, s_impl = 1'b1;
  logic [XLEN-1:0] rs1_val = '0, rs2_val = '0, sepc = '0;
  logic            spp = 1'b0, spie = 1'b0;
  logic            illegal, flush_req, flush_addr_vld, flush_asid_vld, ret_req;
  logic [XLEN-1:0] flush_addr, flush_asid, ret_pc;
  logic [1:0]      ret_priv;
  logic            ret_sie, ret_spie, ret_spp;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  sys_instr_check #(.XLEN(XLEN)) u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] fence_w(input logic [4:0] r1, input logic [4:0] r2);
    return {7'h09, r2, r1, 15'h0073};
  endfunction

  task automatic chk(input string tag, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [1:0] p, input logic t_vm,
                       input logic t_sr, input logic si);
    @(negedge clk);
    instr = w; priv = p; tvm = t_vm; tsr = t_sr; s_impl = si; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic flags(input string tag, input logic e_ill, input logic e_fl, input logic e_rt);
    chk({tag, " illegal"}, XLEN'(illegal), XLEN'(e_ill));
    chk({tag, " flush"},   XLEN'(flush_req), XLEN'(e_fl));
    chk({tag, " return"},  XLEN'(ret_req), XLEN'(e_rt));
  endtask

  task automatic t_reset();
    flags("R12 reset", 0, 0, 0);
    chk("R12 reset ret_pc", ret_pc, '0);
  endtask

  task automatic t_fence_priv();
    issue(fence_w(5'd0, 5'd0), 2'b00, 0, 0, 1); flags("R3 fence user", 1, 0, 0);
    issue(fence_w(5'd0, 5'd0), 2'b01, 1, 0, 1); flags("R4 fence S tvm=1", 1, 0, 0);
    issue(fence_w(5'd0, 5'd0), 2'b01, 0, 0, 1); flags("R4 fence S tvm=0", 0, 1, 0);
    issue(fence_w(5'd0, 5'd0), 2'b11, 1, 0, 1); flags("R5 fence M tvm=1", 0, 1, 0);
    issue(fence_w(5'd0, 5'd0), 2'b11, 0, 0, 1); flags("R5 fence M tvm=0", 0, 1, 0);
  endtask

  task automatic t_qualifiers();
    rs1_val = 64'hDEAD_BEEF_0000_1000; rs2_val = 64'h0000_0000_0000_0042;
    issue(fence_w(5'd0, 5'd0), 2'b11, 0, 0, 1);
    chk("R6 all addr vld", XLEN'(flush_addr_vld), 0);
    chk("R6 all addr",     flush_addr, '0);
    chk("R7 all asid vld", XLEN'(flush_asid_vld), 0);
    chk("R7 all asid",     flush_asid, '0);
    issue(fence_w(5'd7, 5'd3), 2'b01, 0, 0, 1);
    chk("R6 addr vld", XLEN'(flush_addr_vld), 1);
    chk("R6 addr",     flush_addr, 64'hDEAD_BEEF_0000_1000);
    chk("R7 asid vld", XLEN'(flush_asid_vld), 1);
    chk("R7 asid",     flush_asid, 64'h42);
    rs1_val = '0;
    issue(fence_w(5'd9, 5'd0), 2'b11, 0, 0, 1);
    chk("R6 zero value addr vld", XLEN'(flush_addr_vld), 1);
    chk("R7 asid-only all",       XLEN'(flush_asid_vld), 0);
  endtask

  task automatic t_decode();
    issue({7'h0A, 5'd0, 5'd0, 15'h0073}, 2'b00, 0, 0, 1); flags("R1 funct7 off", 0, 0, 0);
    issue({7'h09, 5'd0, 5'd0, 15'h00F3}, 2'b00, 0, 0, 1); flags("R1 low bits off", 0, 0, 0);
    issue(32'h1050_0073, 2'b00, 0, 0, 1); flags("R2 other system word", 0, 0, 0);
    issue(32'h1020_00F3, 2'b00, 0, 0, 1); flags("R2 return word bit off", 0, 0, 0);
    issue(32'h0000_0013, 2'b11, 0, 0, 1); flags("R1 plain op", 0, 0, 0);
  endtask

  task automatic t_sret_legality();
    issue(32'h1020_0073, 2'b00, 0, 0, 1); flags("R8 return user", 1, 0, 0);
    issue(32'h1020_0073, 2'b01, 0, 1, 1); flags("R9 return S tsr", 1, 0, 0);
    issue(32'h1020_0073, 2'b01, 0, 0, 0); flags("R9 return S no smode", 1, 0, 0);
    issue(32'h1020_0073, 2'b11, 0, 1, 0); flags("R9 return M no smode", 1, 0, 0);
    issue(32'h1020_0073, 2'b11, 0, 1, 1); flags("R9 return M tsr ignored", 0, 0, 1);
    issue(32'h1020_0073, 2'b01, 1, 0, 1); flags("R9 return S legal", 0, 0, 1);
  endtask

  task automatic t_sret_state();
    sepc = 64'h0000_0000_8000_0ABC; spp = 1; spie = 1;
    issue(32'h1020_0073, 2'b01, 0, 0, 1);
    chk("R10 pc",   ret_pc, 64'h8000_0ABC);
    chk("R10 priv", XLEN'(ret_priv), 1);
    chk("R10 sie",  XLEN'(ret_sie), 1);
    chk("R10 spie", XLEN'(ret_spie), 1);
    chk("R10 spp",  XLEN'(ret_spp), 0);
    sepc = 64'h1234; spp = 0; spie = 0;
    issue(32'h1020_0073, 2'b11, 0, 0, 1);
    chk("R10 pc b",   ret_pc, 64'h1234);
    chk("R10 priv b", XLEN'(ret_priv), 0);
    chk("R10 sie b",  XLEN'(ret_sie), 0);
    chk("R10 spie b", XLEN'(ret_spie), 1);
  endtask

  task automatic t_timing();
    issue(fence_w(5'd0, 5'd0), 2'b11, 0, 0, 1);
    flags("R11 pulse high", 0, 1, 0);
    @(negedge clk);
    flags("R11 pulse ends", 0, 0, 0);
    @(negedge clk);
    instr = fence_w(5'd0, 5'd0); priv = 2'b11; instr_valid = 1'b0;
    @(negedge clk);
    flags("R11 valid low", 0, 0, 0);
    issue(fence_w(5'd0, 5'd0), 2'b10, 0, 0, 1); flags("R11 reserved priv fence", 1, 0, 0);
    issue(32'h1020_0073, 2'b10, 0, 0, 1); flags("R11 reserved priv return", 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_fence_priv();
    t_qualifiers();
    t_decode();
    t_sret_legality();
    t_sret_state();
    t_timing();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule